// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that walks a device lifecycle transition from request to completion. After reset it settles in an idle state. A transition request then moves it through a fixed run of steps: switch the clock source, bump the transition counter, program that counter, validate the requested transition and hash the supplied token. Transitions flagged as needing a token check take a longer path after hashing: a flash wipe step, then two token comparison stages, before the final programming step. Every run ends in a terminal post-transition state, which carries an error code naming the step that failed, or zero on success.

The work each step stands for is done outside this block: hashing, flash erase, OTP writes and clock switching. The block raises a step-request flag while it waits in a step state. The engine answers on a shared done/pass pair, and the block reads that pair only in the cycle where done is high. Any number of escalation inputs (two by default) can each force the machine into a terminal escalate state. The state register uses a triple-redundant code, so a single flipped bit is caught and sends the machine to an invalid terminal state.

Top module: `life_xfer_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes BOOT (code 0x0F0), `err_o` becomes 0 and `step_req_o` becomes 0. The first edge with `rst` low moves BOOT to IDLE (0x1E1).
- R2: In IDLE with no escalation, `scrap_i` moves the machine to SCRAP (0xC3C). Otherwise `req_i` moves it to CLKSW (0x2D2). `scrap_i` wins when both are high, and IDLE holds when neither is high.
- R3: In any step state, the state holds while `step_done_i` is low and no escalation is present.
- R4: When `step_done_i` is high and the pass input is high, the machine steps CLKSW → CINC (0x3C3) → CPRG (0x4B4) → VCHK (0x5A5) → HASH (0x696). CLKSW advances on done whatever the pass input says.
- R5: On a pass in HASH, the machine goes to WIPE (0x787) if `tok_need_i` was high during the last IDLE cycle, and to COMMIT (0xA5A) otherwise. WIPE goes to TOK0 (0x878) on done whatever the pass input says. TOK0 passes to TOK1 (0x969), TOK1 passes to COMMIT, and a pass in COMMIT gives DONE (0xB4B) with `err_o` = 0.
- R6: When done is high and the pass input is low in CINC, CPRG, VCHK, HASH, TOK0, TOK1 or COMMIT, the machine goes to DONE and `err_o` takes the failing state's index (the top nibble of its code: 3, 4, 5, 6, 8, 9, 10).
- R7: Any bit of `esc_i` moves the machine to ESC (0xD2D) on the next edge. This applies from IDLE, from any step state, from DONE and from BAD. Escalation overrides every other input, and `err_o` is left unchanged.
- R8: SCRAP and ESC are kept against every input, escalation included. DONE and BAD are kept against every input except escalation.
- R9: A state register value that is not a legal code moves the machine to BAD (0xE1E) on the next edge, with `err_o` = 0xF.
- R10: `step_req_o` is high exactly when the state is one of CLKSW, CINC, CPRG, VCHK, HASH, WIPE, TOK0, TOK1 or COMMIT.
- R11: State i (BOOT 0 through BAD 14) is coded as {i, ~i, i} on 4-bit fields. Any two codes therefore differ in at least 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transition request, seen in IDLE |
| tok_need_i | input | 1 | Transition needs the wipe and token-compare path, sampled in IDLE |
| scrap_i | input | 1 | Move to SCRAP, seen in IDLE |
| step_done_i | input | 1 | The current step's engine has finished |
| step_pass_i | input | 1 | Result of the finished step (1 = pass) |
| esc_i | input | NUM_ESC | Escalation inputs; any one set forces ESC |
| step_req_o | output | 1 | Registered flag: a step is awaiting its engine |
| state_o | output | 12 | Registered state code |
| err_o | output | 4 | Registered error code: 0 = none, 0xF = illegal state |

## Verification
The bench fails every fail-capable stage in turn and checks that DONE carries that stage's own index. A design that latched the wrong index, or let a failure fall through to the next stage, would show up as a code or state mismatch. It escalates from IDLE, from every step state, from DONE and from an injected illegal code, alternating between the two inputs. A design that honoured only one input, or let a done/pass in the same cycle win over escalation, would end somewhere other than ESC. It also checks the cases that are easy to get wrong: scrap winning over request, CLKSW and WIPE ignoring the pass input, the token flag choosing WIPE or COMMIT after hashing, and SCRAP/ESC refusing escalation.

// File: rtl/lxs_pkg.sv
package lxs_pkg;
  localparam int IDX_W  = 4;
  localparam int CODE_W = 3 * IDX_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // code for index i is {i, ~i, i}
  localparam code_t S_BOOT   = 12'h0F0;
  localparam code_t S_IDLE   = 12'h1E1;
  localparam code_t S_CLKSW  = 12'h2D2;
  localparam code_t S_CINC   = 12'h3C3;
  localparam code_t S_CPRG   = 12'h4B4;
  localparam code_t S_VCHK   = 12'h5A5;
  localparam code_t S_HASH   = 12'h696;
  localparam code_t S_WIPE   = 12'h787;
  localparam code_t S_TOK0   = 12'h878;
  localparam code_t S_TOK1   = 12'h969;
  localparam code_t S_COMMIT = 12'hA5A;
  localparam code_t S_DONE   = 12'hB4B;
  localparam code_t S_SCRAP  = 12'hC3C;
  localparam code_t S_ESC    = 12'hD2D;
  localparam code_t S_BAD    = 12'hE1E;

  localparam idx_t LAST_IDX    = 4'd14;
  localparam idx_t ERR_NONE    = 4'h0;
  localparam idx_t ERR_ILLEGAL = 4'hF;

  function automatic idx_t code_idx(code_t c);
    return c[CODE_W-1 -: IDX_W];
  endfunction

  function automatic logic code_ok(code_t c);
    idx_t h;
    h = c[CODE_W-1 -: IDX_W];
    return (c[2*IDX_W-1 -: IDX_W] == ~h) && (c[IDX_W-1:0] == h) && (h <= LAST_IDX);
  endfunction

  function automatic logic is_step(code_t c);
    return (c == S_CLKSW) || (c == S_CINC) || (c == S_CPRG) || (c == S_VCHK) ||
           (c == S_HASH)  || (c == S_WIPE) || (c == S_TOK0) || (c == S_TOK1) ||
           (c == S_COMMIT);
  endfunction

  function automatic logic can_escalate(code_t c);
    return is_step(c) || (c == S_IDLE) || (c == S_DONE) || (c == S_BAD);
  endfunction
endpackage

// File: rtl/lxs_esc_merge.sv
module lxs_esc_merge #(
  parameter int NUM_ESC = 2
) (
  input  logic [NUM_ESC-1:0] esc_i,
  output logic               esc_o
);
  logic [NUM_ESC:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_ESC; g++) begin : g_or
    assign chain[g+1] = chain[g] | esc_i[g];
  end
  assign esc_o = chain[NUM_ESC];
endmodule

// File: rtl/lxs_next.sv
module lxs_next
  import lxs_pkg::*;
(
  input  code_t state_q,
  input  logic  tok_q,
  input  logic  esc,
  input  logic  req,
  input  logic  scrap,
  input  logic  done,
  input  logic  pass,
  output code_t state_d,
  output logic  err_we,
  output idx_t  err_d
);
  code_t pass_next;

  always_comb begin
    case (state_q)
      S_CINC:   pass_next = S_CPRG;
      S_CPRG:   pass_next = S_VCHK;
      S_VCHK:   pass_next = S_HASH;
      S_HASH:   pass_next = tok_q ? S_WIPE : S_COMMIT;
      S_TOK0:   pass_next = S_TOK1;
      S_TOK1:   pass_next = S_COMMIT;
      default:  pass_next = S_DONE;
    endcase
  end

  always_comb begin
    state_d = state_q;
    err_we  = 1'b0;
    err_d   = ERR_NONE;
    case (state_q)
      S_BOOT: state_d = S_IDLE;
      S_IDLE: begin
        if (esc)        state_d = S_ESC;
        else if (scrap) state_d = S_SCRAP;
        else if (req)   state_d = S_CLKSW;
      end
      S_CLKSW: begin
        if (esc)       state_d = S_ESC;
        else if (done) state_d = S_CINC;
      end
      S_WIPE: begin
        if (esc)       state_d = S_ESC;
        else if (done) state_d = S_TOK0;
      end
      S_CINC, S_CPRG, S_VCHK, S_HASH, S_TOK0, S_TOK1, S_COMMIT: begin
        if (esc) begin
          state_d = S_ESC;
        end else if (done) begin
          if (pass) begin
            state_d = pass_next;
          end else begin
            state_d = S_DONE;
            err_we  = 1'b1;
            err_d   = code_idx(state_q);
          end
        end
      end
      S_DONE, S_BAD: begin
        if (esc) state_d = S_ESC;
      end
      S_SCRAP, S_ESC: state_d = state_q;
      default: begin
        state_d = S_BAD;
        err_we  = 1'b1;
        err_d   = ERR_ILLEGAL;
      end
    endcase
  end
endmodule

// File: rtl/lxs_state_reg.sv
module lxs_state_reg
  import lxs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  code_t state_d,
  input  logic  err_we,
  input  idx_t  err_d,
  input  logic  tok_in,
  output code_t state_q,
  output idx_t  err_q,
  output logic  tok_q,
  output logic  step_req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_BOOT;
      err_q      <= ERR_NONE;
      tok_q      <= 1'b0;
      step_req_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      step_req_q <= is_step(state_d);
      if (err_we) err_q <= err_d;
      if (state_q == S_IDLE) tok_q <= tok_in;
    end
  end
endmodule

// File: rtl/life_xfer_seq.sv
module life_xfer_seq
  import lxs_pkg::*;
#(
  parameter int NUM_ESC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic                tok_need_i,
  input  logic                scrap_i,
  input  logic                step_done_i,
  input  logic                step_pass_i,
  input  logic [NUM_ESC-1:0]  esc_i,
  output logic                step_req_o,
  output logic [CODE_W-1:0]   state_o,
  output logic [IDX_W-1:0]    err_o
);
  logic  esc_any;
  code_t state_q, state_d;
  logic  err_we;
  idx_t  err_d, err_q;
  logic  tok_q, step_req_q;

  lxs_esc_merge #(.NUM_ESC(NUM_ESC)) u_esc (
    .esc_i (esc_i),
    .esc_o (esc_any)
  );

  lxs_next u_next (
    .state_q (state_q),
    .tok_q   (tok_q),
    .esc     (esc_any),
    .req     (req_i),
    .scrap   (scrap_i),
    .done    (step_done_i),
    .pass    (step_pass_i),
    .state_d (state_d),
    .err_we  (err_we),
    .err_d   (err_d)
  );

  lxs_state_reg u_reg (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .err_we     (err_we),
    .err_d      (err_d),
    .tok_in     (tok_need_i),
    .state_q    (state_q),
    .err_q      (err_q),
    .tok_q      (tok_q),
    .step_req_q (step_req_q)
  );

  assign state_o    = state_q;
  assign err_o      = err_q;
  assign step_req_o = step_req_q;
endmodule

// File: rtl/lxs_seq_chk.sv
module lxs_seq_chk
  import lxs_pkg::*;
#(
  parameter int NUM_ESC = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               step_done_i,
  input logic               step_pass_i,
  input logic [NUM_ESC-1:0] esc_i,
  input logic               step_req_o,
  input logic [CODE_W-1:0]  state_o,
  input logic [IDX_W-1:0]   err_o
);
  // R1
  boot_exit_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == S_BOOT |=> state_o == S_IDLE);

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_req_o && !step_done_i && !(|esc_i)) |=> state_o == $past(state_o));

  // R6
  fail_code_chk: assert property (@(posedge clk) disable iff (rst)
    (step_req_o && step_done_i && !step_pass_i && !(|esc_i) &&
     state_o != S_CLKSW && state_o != S_WIPE)
    |=> (state_o == S_DONE && err_o == $past(code_idx(state_o))));

  // R7
  esc_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((|esc_i) && can_escalate(state_o)) |=> state_o == S_ESC);

  // R8
  scrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == S_SCRAP |=> state_o == S_SCRAP);

  // R8
  esc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == S_ESC |=> (state_o == S_ESC && $stable(err_o)));

  // R9
  illegal_chk: assert property (@(posedge clk) disable iff (rst)
    !code_ok(state_o) |=> (state_o == S_BAD && err_o == ERR_ILLEGAL));

  // R10
  step_flag_chk: assert property (@(posedge clk) disable iff (rst)
    step_req_o == is_step(state_o));
endmodule

bind life_xfer_seq lxs_seq_chk #(.NUM_ESC(NUM_ESC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .step_done_i (step_done_i),
  .step_pass_i (step_pass_i),
  .esc_i       (esc_i),
  .step_req_o  (step_req_o),
  .state_o     (state_o),
  .err_o       (err_o)
);

// File: tb/life_xfer_seq_bench.sv
`timescale 1ns/1ps
module life_xfer_seq_bench;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 0, tok = 0, scrap = 0, done = 0, pass = 0;
  logic [NE-1:0] esc = '0;
  logic step_req;
  logic [11:0] state;
  logic [3:0] err;

  int vectors = 0;
  int miscompares = 0;

  typedef struct packed { logic [11:0] st; logic [3:0] er; logic [7:0] rq; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  life_xfer_seq #(.NUM_ESC(NE)) u_life_xfer_seq (
    .clk(clk), .rst(rst), .req_i(req), .tok_need_i(tok), .scrap_i(scrap),
    .step_done_i(done), .step_pass_i(pass), .esc_i(esc),
    .step_req_o(step_req), .state_o(state), .err_o(err)
  );

  // R11: code for index i is {i, ~i, i}
  function automatic logic [11:0] enc(int i);
    logic [3:0] n = 4'(i);
    return {n, ~n, n};
  endfunction

  // R10: step states are indices 2..10
  function automatic logic step_of(logic [11:0] c);
    return (c[11:8] >= 4'd2) && (c[11:8] <= 4'd10);
  endfunction

  task automatic check(logic [11:0] est, logic [3:0] eer, int rq);
    vectors++;
    if (state !== est || err !== eer || step_req !== step_of(est)) begin
      miscompares++;
      $display("FAIL R%0d: state=%h err=%h step_req=%b expected state=%h err=%h step_req=%b",
               rq, state, err, step_req, est, eer, step_of(est));
    end
  endtask

  // monitor: compares the result of each clock edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.st, e.er, int'(e.rq));
    end
  end

  task automatic drive(logic r, logic t, logic s, logic d, logic p, logic [NE-1:0] e,
                       logic [11:0] est, logic [3:0] eer, int rq);
    @(negedge clk);
    req = r; tok = t; scrap = s; done = d; pass = p; esc = e;
    sb_q.push_back('{st: est, er: eer, rq: 8'(rq)});
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    rst = 1; req = 0; tok = 0; scrap = 0; done = 0; pass = 0; esc = '0;
    @(negedge clk);
    check(enc(0), 4'h0, 1);   // R1 reset state
    rst = 0;
    @(negedge clk);
    check(enc(1), 4'h0, 1);   // R1 boot exits to idle
  endtask

  // token path order, by state index
  function automatic int path_idx(int k);
    int p[9] = '{2, 3, 4, 5, 6, 7, 8, 9, 10};
    return p[k];
  endfunction

  // from IDLE, walk the token path until the state at position n
  task automatic walk_to(int n);
    drive(1, 1, 0, 0, 0, '0, enc(2), 4'h0, 2);        // R2
    for (int k = 1; k <= n; k++)
      drive(0, 1, 0, 1, 1, '0, enc(path_idx(k)), 4'h0, 5);
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL R1: watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    drive(0, 0, 0, 0, 0, '0, enc(1), 4'h0, 2);        // R2 idle holds

    // R4 R5 plain path, no token
    drive(1, 0, 0, 0, 0, '0, enc(2), 4'h0, 2);
    drive(0, 0, 0, 0, 1, '0, enc(2), 4'h0, 3);        // R3 waits for done
    drive(0, 0, 0, 1, 0, '0, enc(3), 4'h0, 4);        // R4 CLKSW ignores pass
    drive(0, 0, 0, 0, 0, '0, enc(3), 4'h0, 3);
    drive(0, 0, 0, 1, 1, '0, enc(4), 4'h0, 4);
    drive(0, 0, 0, 1, 1, '0, enc(5), 4'h0, 4);
    drive(0, 0, 0, 1, 1, '0, enc(6), 4'h0, 4);
    drive(0, 0, 0, 1, 1, '0, enc(10), 4'h0, 5);       // R5 no token -> COMMIT
    drive(0, 0, 0, 1, 1, '0, enc(11), 4'h0, 5);
    drive(1, 0, 1, 1, 0, '0, enc(11), 4'h0, 8);       // R8 DONE holds
    drive(0, 0, 0, 0, 0, 2'b10, enc(13), 4'h0, 7);    // R7 DONE -> ESC

    // R5 token path, WIPE ignores pass
    do_reset();
    walk_to(4);
    drive(0, 0, 0, 1, 1, '0, enc(7), 4'h0, 5);
    drive(0, 0, 0, 0, 1, '0, enc(7), 4'h0, 3);
    drive(0, 0, 0, 1, 0, '0, enc(8), 4'h0, 5);
    drive(0, 0, 0, 1, 1, '0, enc(9), 4'h0, 5);
    drive(0, 0, 0, 1, 1, '0, enc(10), 4'h0, 5);
    drive(0, 0, 0, 1, 1, '0, enc(11), 4'h0, 5);

    // R6 failure at every fail-capable stage
    for (int k = 1; k <= 8; k++) begin
      if (k == 5) continue;
      do_reset();
      walk_to(k);
      drive(0, 0, 0, 1, 0, '0, enc(11), 4'(path_idx(k)), 6);
      drive(0, 0, 0, 1, 1, '0, enc(11), 4'(path_idx(k)), 8);
    end

    // R7 escalation from idle and each step state, alternating inputs
    for (int k = -1; k <= 8; k++) begin
      do_reset();
      if (k >= 0) walk_to(k);
      drive(1, 0, 1, 1, 1, (k % 2 == 0) ? 2'b01 : 2'b10, enc(13), 4'h0, 7);
      drive(0, 0, 0, 0, 0, '0, enc(13), 4'h0, 8);
    end

    // R2 scrap beats request; R8 scrap ignores escalation
    do_reset();
    drive(1, 0, 1, 0, 0, '0, enc(12), 4'h0, 2);
    drive(1, 0, 0, 1, 1, 2'b11, enc(12), 4'h0, 8);

    // R8 escalate ignores everything
    do_reset();
    drive(0, 0, 0, 0, 0, 2'b01, enc(13), 4'h0, 7);
    drive(1, 0, 1, 1, 0, 2'b00, enc(13), 4'h0, 8);

    // R9 illegal code (single-bit upset of IDLE) -> BAD, then R7 from BAD
    do_reset();
    drain();
    @(negedge clk);
    force u_life_xfer_seq.u_reg.state_q = 12'h1E0;
    #1 release u_life_xfer_seq.u_reg.state_q;
    sb_q.push_back('{st: enc(14), er: 4'hF, rq: 8'd9});
    drive(1, 0, 0, 1, 1, '0, enc(14), 4'hF, 8);
    drive(0, 0, 0, 0, 0, 2'b10, enc(13), 4'hF, 7);

    drain();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule